// File: doc/BRIEF.md
# Landscape-to-Portrait Pixel Rotator

This block turns a landscape framebuffer into a byte stream for a portrait display panel. It reads a 320-column by 240-row image of 16-bit pixels through a synchronous read port. The port takes an address and a read enable, and returns data a fixed number of cycles later. The block sends the pixels out in the raster order of a 240-wide by 320-tall panel, so the picture appears turned by a quarter turn. Each source row becomes one panel column. The first pixel of a source row goes to the bottom of that column.

A one-cycle start pulse launches a frame. The block generates the transposed, row-reversed read addresses and tracks the read latency. It buffers a small number of returned pixels and splits each pixel into bytes, most significant byte first. The bytes leave over a valid/ready stream toward a serial transmitter. Backpressure on that stream stalls the address generator, so no byte is lost or repeated. A one-cycle done pulse marks the end of the frame.

Top module: `rot_pixel_rotator`

## Requirements
- R1: After reset, out_valid, done and rd_en are all low.
- R2: A start pulse while idle begins a frame. The first read of the frame is at source address SRC_W-1, which is column SRC_W-1 of row 0.
- R3: Panel pixel k of a frame (panel row r = k / SRC_H, panel column c = k mod SRC_H, counted in raster order) is source pixel address c*SRC_W + (SRC_W-1-r). The source is stored row-major with address = row*SRC_W + column.
- R4: Each pixel leaves as two bytes: bits 15:8 in the first accepted byte and bits 7:0 in the second.
- R5: A frame carries exactly SRC_W*SRC_H pixels, which is twice that many bytes. Afterwards out_valid and rd_en stay low until the next start.
- R6: done is high for exactly one cycle: the cycle after the final byte of the frame is accepted.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_data keeps its value on the next cycle.
- R8: Under any pattern of out_ready, the accepted byte sequence is exactly the sequence of R3 and R4, with no byte dropped or repeated.
- R9: A start pulse that arrives while a frame is in progress has no effect on the stream of that frame, and no second frame follows.
- R10: rd_data is used only in the cycle RD_LAT cycles after the matching rd_en. With the default RD_LAT of 1, this is the cycle after the read. rd_data in any other cycle has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that launches a frame when idle |
| done | output | 1 | One-cycle pulse after the last byte is accepted |
| rd_en | output | 1 | Framebuffer read strobe |
| rd_addr | output | AW | Framebuffer read address, row-major |
| rd_data | input | PIX_W | Framebuffer read data, RD_LAT cycles after rd_en |
| out_valid | output | 1 | Output byte available |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | BYTE_W | Output byte |

## Verification
The assertions assume that the framebuffer returns data exactly RD_LAT cycles after each rd_en. They also assume that start is a single-cycle pulse and that out_ready may change freely. The read-address step check relies on the frame beginning only from start while idle, or in the cycle of done. The bench models the framebuffer with a one-cycle registered read and drives an obvious garbage word in every cycle with no read. It drives start only as single-cycle pulses, and it varies out_ready only at falling edges: always high, a pseudo-random pattern, and a one-in-three pattern.

// File: rtl/rot_pkg.sv
package rot_pkg;
   typedef enum logic {
      FR_IDLE = 1'b0,
      FR_RUN  = 1'b1
   } frame_state_e;

   localparam int unsigned DEF_SRC_W  = 320;
   localparam int unsigned DEF_SRC_H  = 240;
   localparam int unsigned DEF_PIX_W  = 16;
   localparam int unsigned DEF_BYTE_W = 8;
endpackage

// File: rtl/rot_addr_gen.sv
// Walks the source image column-major in reverse column order: for each
// panel row r, visits source rows 0..SRC_H-1 at source column SRC_W-1-r.
module rot_addr_gen #(
   parameter int unsigned SRC_W = 320,
   parameter int unsigned SRC_H = 240,
   parameter int unsigned AW    = 17
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   output logic          active,
   output logic [AW-1:0] addr
);
   localparam int unsigned CW = (SRC_H > 1) ? $clog2(SRC_H) : 1;
   localparam int unsigned RW = (SRC_W > 1) ? $clog2(SRC_W) : 1;

   logic [CW-1:0] col_q;
   logic [RW-1:0] row_q;
   logic [AW-1:0] base_q;
   logic [AW-1:0] addr_q;
   logic          act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q  <= '0;
         row_q  <= '0;
         base_q <= '0;
         addr_q <= '0;
         act_q  <= 1'b0;
      end else if (load) begin
         col_q  <= '0;
         row_q  <= '0;
         base_q <= AW'(SRC_W - 1);
         addr_q <= AW'(SRC_W - 1);
         act_q  <= 1'b1;
      end else if (step && act_q) begin
         if (col_q == CW'(SRC_H - 1)) begin
            col_q <= '0;
            if (row_q == RW'(SRC_W - 1)) begin
               act_q <= 1'b0;
            end else begin
               row_q  <= row_q + 1'b1;
               base_q <= base_q - 1'b1;
               addr_q <= base_q - 1'b1;
            end
         end else begin
            col_q  <= col_q + 1'b1;
            addr_q <= addr_q + AW'(SRC_W);
         end
      end
   end

   assign active = act_q;
   assign addr   = addr_q;
endmodule

// File: rtl/rot_rd_track.sv
// Tracks outstanding framebuffer reads of fixed latency RD_LAT.
module rot_rd_track #(
   parameter int unsigned RD_LAT = 1,
   localparam int unsigned LW    = $clog2(RD_LAT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          issue,
   output logic          ret,
   output logic [LW-1:0] inflight
);
   generate
      if (RD_LAT == 1) begin : g_single
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= issue;
         end
         assign ret      = q;
         assign inflight = LW'(q);
      end else begin : g_pipe
         logic [RD_LAT-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[RD_LAT-2:0], issue};
         end
         assign ret      = sh_q[RD_LAT-1];
         assign inflight = LW'($countones(sh_q));
      end
   endgenerate
endmodule

// File: rtl/rot_pix_fifo.sv
module rot_pix_fifo #(
   parameter int unsigned W     = 16,
   parameter int unsigned DEPTH = 2,
   localparam int unsigned CNTW = $clog2(DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            push,
   input  logic [W-1:0]    din,
   input  logic            pop,
   output logic [W-1:0]    dout,
   output logic [CNTW-1:0] count
);
   localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [W-1:0]    mem [DEPTH];
   logic [PW-1:0]   wr_q;
   logic [PW-1:0]   rd_q;
   logic [CNTW-1:0] cnt_q;

   function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (push) mem[wr_q] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wr_q <= bump(wr_q);
         if (pop)  rd_q <= bump(rd_q);
         if (push && !pop)      cnt_q <= cnt_q + 1'b1;
         else if (pop && !push) cnt_q <= cnt_q - 1'b1;
      end
   end

   assign dout  = mem[rd_q];
   assign count = cnt_q;
endmodule

// File: rtl/rot_byte_ser.sv
// Splits the head pixel into bytes, most significant first.
module rot_byte_ser #(
   parameter int unsigned PIX_W  = 16,
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              have,
   input  logic [PIX_W-1:0]  head,
   input  logic              ready,
   output logic              valid,
   output logic [BYTE_W-1:0] data,
   output logic              pix_pop
);
   localparam int unsigned BPP = PIX_W / BYTE_W;
   localparam int unsigned SW  = (BPP > 1) ? $clog2(BPP) : 1;

   logic [SW-1:0] sel_q;
   logic          fire;

   assign valid   = have;
   assign fire    = have && ready;
   assign pix_pop = fire && (sel_q == SW'(BPP - 1));

   always_comb begin
      data = head[(BPP - 1 - int'(sel_q)) * BYTE_W +: BYTE_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sel_q <= '0;
      else if (pix_pop) sel_q <= '0;
      else if (fire)    sel_q <= sel_q + 1'b1;
   end
endmodule

// File: rtl/rot_pixel_rotator.sv
module rot_pixel_rotator
   import rot_pkg::*;
#(
   parameter int unsigned SRC_W      = DEF_SRC_W,
   parameter int unsigned SRC_H      = DEF_SRC_H,
   parameter int unsigned PIX_W      = DEF_PIX_W,
   parameter int unsigned BYTE_W     = DEF_BYTE_W,
   parameter int unsigned RD_LAT     = 1,
   parameter int unsigned FIFO_DEPTH = 2,
   localparam int unsigned AW        = $clog2(SRC_W * SRC_H)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              done,
   output logic              rd_en,
   output logic [AW-1:0]     rd_addr,
   input  logic [PIX_W-1:0]  rd_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [BYTE_W-1:0] out_data
);
   localparam int unsigned NPIX = SRC_W * SRC_H;
   localparam int unsigned NW   = $clog2(NPIX);
   localparam int unsigned CNTW = $clog2(FIFO_DEPTH + 1);
   localparam int unsigned LW   = $clog2(RD_LAT + 1);

   generate
      if (PIX_W % BYTE_W != 0 || PIX_W / BYTE_W < 2) begin : g_bad_width
         $error("PIX_W must be a multiple of BYTE_W, at least two bytes");
      end
      if (SRC_W < 2 || SRC_H < 2) begin : g_bad_size
         $error("SRC_W and SRC_H must be at least 2");
      end
      if (RD_LAT < 1 || FIFO_DEPTH < 1) begin : g_bad_depth
         $error("RD_LAT and FIFO_DEPTH must be at least 1");
      end
   endgenerate

   frame_state_e    st_q;
   logic [NW-1:0]   pix_cnt_q;
   logic            done_q;
   logic            go;
   logic            gen_active;
   logic [AW-1:0]   gen_addr;
   logic            issue;
   logic            ret;
   logic [LW-1:0]   inflight;
   logic [PIX_W-1:0] head;
   logic [CNTW-1:0] fifo_cnt;
   logic            pop;

   assign go = start && (st_q == FR_IDLE);

   rot_addr_gen #(.SRC_W(SRC_W), .SRC_H(SRC_H), .AW(AW)) addr_i (
      .clk(clk), .rst_n(rst_n), .load(go), .step(issue),
      .active(gen_active), .addr(gen_addr)
   );

   // Issue only when the pixel slots can absorb every read in flight.
   always_comb begin
      issue = gen_active &&
              ((int'(fifo_cnt) + int'(inflight) - int'(pop)) < int'(FIFO_DEPTH));
   end

   rot_rd_track #(.RD_LAT(RD_LAT)) trk_i (
      .clk(clk), .rst_n(rst_n), .issue(issue), .ret(ret), .inflight(inflight)
   );

   rot_pix_fifo #(.W(PIX_W), .DEPTH(FIFO_DEPTH)) fifo_i (
      .clk(clk), .rst_n(rst_n), .push(ret), .din(rd_data),
      .pop(pop), .dout(head), .count(fifo_cnt)
   );

   rot_byte_ser #(.PIX_W(PIX_W), .BYTE_W(BYTE_W)) ser_i (
      .clk(clk), .rst_n(rst_n), .have(fifo_cnt != '0), .head(head),
      .ready(out_ready), .valid(out_valid), .data(out_data), .pix_pop(pop)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= FR_IDLE;
         pix_cnt_q <= '0;
         done_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (go) begin
            st_q      <= FR_RUN;
            pix_cnt_q <= '0;
         end else if (pop) begin
            if (pix_cnt_q == NW'(NPIX - 1)) begin
               st_q      <= FR_IDLE;
               pix_cnt_q <= '0;
               done_q    <= 1'b1;
            end else begin
               pix_cnt_q <= pix_cnt_q + 1'b1;
            end
         end
      end
   end

   assign done    = done_q;
   assign rd_en   = issue;
   assign rd_addr = gen_addr;
endmodule

// File: rtl/rot_pixel_rotator_chk.sv
module rot_pixel_rotator_chk #(
   parameter int unsigned SRC_W  = 320,
   parameter int unsigned SRC_H  = 240,
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned AW     = 17
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              done,
   input logic              rd_en,
   input logic [AW-1:0]     rd_addr,
   input logic              out_valid,
   input logic              out_ready,
   input logic [BYTE_W-1:0] out_data
);
   localparam int LASTCOL = int'(SRC_W * (SRC_H - 1));

   logic open_q;
   logic first_q;
   int   prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q  <= 1'b0;
         first_q <= 1'b0;
         prev_q  <= 0;
      end else begin
         if (start && (!open_q || done)) begin
            open_q  <= 1'b1;
            first_q <= 1'b1;
         end else if (done) begin
            open_q <= 1'b0;
         end
         if (rd_en) begin
            first_q <= 1'b0;
            prev_q  <= int'(rd_addr);
            if (first_q) begin
               p_first_addr_r2: assert (int'(rd_addr) == int'(SRC_W) - 1);
            end else if (prev_q >= LASTCOL) begin
               p_col_wrap_r3: assert (int'(rd_addr) == prev_q - LASTCOL - 1);
            end else begin
               p_col_step_r3: assert (int'(rd_addr) == prev_q + int'(SRC_W));
            end
         end
      end
   end

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data));

   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_quiet_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !out_valid && !rd_en);

   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !open_q |-> !out_valid && !rd_en);

   p_addr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> int'(rd_addr) < int'(SRC_W * SRC_H));
endmodule

bind rot_pixel_rotator rot_pixel_rotator_chk #(
   .SRC_W(SRC_W), .SRC_H(SRC_H), .BYTE_W(BYTE_W), .AW(AW)
) chk_i (
   .clk(clk), .rst_n(rst_n), .start(start), .done(done), .rd_en(rd_en),
   .rd_addr(rd_addr), .out_valid(out_valid), .out_ready(out_ready),
   .out_data(out_data)
);

// File: tb/rot_pixel_rotator_tb_top.sv
module rot_pixel_rotator_tb_top;
   localparam int SW = 6;
   localparam int SH = 4;
   localparam int NP = SW * SH;
   localparam int NB = 2 * NP;
   localparam int AW = $clog2(NP);

   logic          clk = 1'b0;
   logic          rst_n;
   logic          start;
   logic          done;
   logic          rd_en;
   logic [AW-1:0] rd_addr;
   logic [15:0]   rd_data;
   logic          out_valid;
   logic          out_ready;
   logic [7:0]    out_data;

   int total = 0;
   int bad   = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   rot_pixel_rotator #(.SRC_W(SW), .SRC_H(SH), .PIX_W(16), .BYTE_W(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .done(done), .rd_en(rd_en),
      .rd_addr(rd_addr), .rd_data(rd_data), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data)
   );

   function automatic logic [15:0] pix_of(input int a);
      return {8'(a * 7 + 49), 8'(192 ^ a)};
   endfunction

   // Framebuffer model: one-cycle registered read; garbage when not read (R10).
   always_ff @(posedge clk) begin
      if (rd_en) rd_data <= pix_of(int'(rd_addr));
      else       rd_data <= 16'hDEAD;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_byte(input int b);
      int k = b / 2;
      int r = k / SH;
      int c = k % SH;
      logic [15:0] p = pix_of(c * SW + (SW - 1 - r));
      return (b % 2 == 0) ? int'(p[15:8]) : int'(p[7:0]);
   endfunction

   task automatic run_frame(input int mode, input int inject, input string tag);
      int   b = 0;
      int   cyc = 0;
      bit   seen_rd = 0;
      bit   got_done = 0;
      bit   chk_hold = 0;
      logic [7:0] held = 8'h00;
      logic [7:0] lfsr = 8'hA5;
      bit   r;
      @(negedge clk);
      start = 1'b1;
      while (!got_done && cyc < 2000) begin
         @(negedge clk);
         cyc++;
         start = (cyc == inject);
         if (chk_hold) begin
            check(out_valid && out_data == held, "R7 hold", int'(out_data), int'(held));
         end
         if (!seen_rd && rd_en) begin
            seen_rd = 1;
            check(int'(rd_addr) == SW - 1, "R2 first read address", int'(rd_addr), SW - 1);
         end
         if (done) begin
            got_done = 1;
            check(b == NB, {"R6 done after last byte, ", tag}, b, NB);
            check(!out_valid, "R5 no byte with done", int'(out_valid), 0);
         end else begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            case (mode)
               0:       r = 1'b1;
               1:       r = lfsr[0] | lfsr[2];
               default: r = (cyc % 3 == 0);
            endcase
            out_ready = r;
            if (out_valid && r) begin
               if (b < NB) begin
                  check(int'(out_data) == exp_byte(b), {tag, " R4 byte order"},
                        int'(out_data), exp_byte(b));
               end else begin
                  check(1'b0, "R5 extra byte", b, NB - 1);
               end
               b++;
            end
            chk_hold = out_valid && !r;
            held = out_data;
         end
      end
      if (!got_done) check(1'b0, "R6 done missing", b, NB);
      out_ready = 1'b1;
      @(negedge clk);
      check(!done, "R6 done one cycle wide", int'(done), 0);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         check(!out_valid && !rd_en, "R5 R9 quiet after frame",
               int'(out_valid) + 2 * int'(rd_en), 0);
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL R5 watchdog actual=hung expected=frame_end");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      start = 1'b0;
      out_ready = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!out_valid, "R1 out_valid after reset", int'(out_valid), 0);
      check(!done, "R1 done after reset", int'(done), 0);
      check(!rd_en, "R1 rd_en after reset", int'(rd_en), 0);
      run_frame(0, -1, "R3 full rate");
      run_frame(1, 7, "R8 R9 random stall with extra start");
      run_frame(2, -1, "R10 sparse ready");
      run_frame(1, 30, "R8 R9 late extra start");
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule